// File: doc/BRIEF.md
# Header-Matched Payload Capture with Parity Error Counting

This block inspects one 12-bit word on every clock edge. The upper four bits name the word's kind, the next four carry a payload, bits 3:1 are spare, and the lowest bit tells the block which parity the payload should have. Only words whose kind field equals 1 are acted on. For each such word the payload is captured into a registered output and a packet counter advances. The payload parity is also compared with the sense requested by that word, and an error counter advances on a mismatch.

Words of any other kind leave every output untouched, so a stream may mix traffic freely. Because a word can arrive on every cycle, consecutive matching words are each captured, counted and checked. An active-low reset and an active-high clear both return all three outputs to zero. Both are sampled on the clock edge, and clear overrides any update in the same cycle.

Top module: `pkt_hdr_filter`

## Requirements
- R1: The input word is split as follows: bits 11:8 are the kind field, bits 7:4 are the payload, and bit 0 is the parity mode.
- R2: When the kind field equals 1 at a clock edge, payload_o shows input bits 7:4 after that edge.
- R3: When the kind field equals 1 at a clock edge, pkt_cnt_o increases by one after that edge.
- R4: Mode bit 1 requires an even number of ones in the payload, and mode bit 0 requires an odd number. A kind-1 word that fails this test raises err_cnt_o by one at the same edge that counts it.
- R5: A word whose kind field is not 1 leaves payload_o, pkt_cnt_o and err_cnt_o unchanged.
- R6: If rst_n is low at a clock edge, all three outputs are zero after that edge.
- R7: If clr is high at a clock edge, all three outputs are zero after that edge, even when the word at that edge is of kind 1.
- R8: Both counters wrap from 255 to 0 and never saturate.
- R9: Matching words on consecutive cycles are each captured, counted and checked, with no cycle lost.
- R10: Input bits 3:1 have no effect on any output.
- R11: The word sequence 0x1F1, 0x0E0, 0x171 gives payload_o values F, F, 7, and ends with a packet count of 2 and an error count of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Reset, active low, sampled on the clock edge |
| clr | input | 1 | Clear, active high, sampled on the clock edge |
| in_word | input | 12 | Input word, one per cycle |
| payload_o | output | 4 | Payload of the most recent kind-1 word |
| pkt_cnt_o | output | 8 | Count of kind-1 words, wrapping |
| err_cnt_o | output | 8 | Count of kind-1 words with wrong parity, wrapping |

## Verification
The assertions assume that clr and in_word are settled before each rising edge. They also assume that reset has been applied once before normal words arrive, so that every comparison against a past value refers to a cycle that reset has defined. The stimulus changes inputs only on the falling edge. It holds rst_n low for the first cycles. Random words are biased so that about half carry kind 1, and spare bits and the mode bit are drawn freely. Clear pulses are placed at random and also next to matching words, which exercises the priority of clear over an update.

// File: rtl/pkt_hdr_pkg.sv
package pkt_hdr_pkg;
  // Field geometry of the incoming word
  parameter int unsigned HDR_W   = 4;
  parameter int unsigned PAY_W   = 4;
  parameter int unsigned SPARE_W = 3;
  parameter int unsigned CNT_W   = 8;
  parameter int unsigned WORD_W  = HDR_W + PAY_W + SPARE_W + 1;

  // Decoded view of one word
  typedef struct packed {
    logic             hit;   // kind field matched
    logic             bad;   // matched and parity wrong
    logic [PAY_W-1:0] pay;   // payload bits
  } dec_t;
endpackage

// File: rtl/pkt_word_decode.sv
module pkt_word_decode
  import pkt_hdr_pkg::*;
#(
  parameter int unsigned MATCH_KIND = 1
) (
  input  logic [WORD_W-1:0] word_i,
  output dec_t              dec_o
);
  localparam int unsigned PAY_LSB = SPARE_W + 1;
  localparam int unsigned HDR_LSB = PAY_LSB + PAY_W;

  logic [HDR_W-1:0] kind;
  logic [PAY_W-1:0] pay;
  logic             want_even;
  logic             ones_odd;

  assign kind      = word_i[HDR_LSB +: HDR_W];
  assign pay       = word_i[PAY_LSB +: PAY_W];
  assign want_even = word_i[0];
  assign ones_odd  = ^pay;

  always_comb begin
    dec_o.hit = (kind == HDR_W'(MATCH_KIND));
    dec_o.pay = pay;
    // even wanted -> odd count is wrong; odd wanted -> even count is wrong
    dec_o.bad = dec_o.hit && (ones_odd == want_even);
  end
endmodule

// File: rtl/pkt_wrap_counter.sv
module pkt_wrap_counter #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) q <= '0;
    else if (inc)      q <= q + W'(1);
  end

  assert_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && inc) |=> (q == $past(q) + W'(1)));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(q));
  assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));
  assert_reset_R6: assert property (@(posedge clk)
    !rst_n |=> (q == '0));
endmodule

// File: rtl/pkt_payload_reg.sv
module pkt_payload_reg #(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n || clr) q <= '0;
    else if (load)     q <= d;
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load) |=> (q == $past(d)));
  assert_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load) |=> $stable(q));
endmodule

// File: rtl/pkt_hdr_filter.sv
module pkt_hdr_filter
  import pkt_hdr_pkg::*;
#(
  parameter int unsigned MATCH_KIND = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [WORD_W-1:0] in_word,
  output logic [PAY_W-1:0]  payload_o,
  output logic [CNT_W-1:0]  pkt_cnt_o,
  output logic [CNT_W-1:0]  err_cnt_o
);
  localparam int unsigned N_CNT = 2;

  dec_t             dec;
  logic [N_CNT-1:0] inc_vec;
  logic [CNT_W-1:0] cnt_arr [N_CNT];

  pkt_word_decode #(.MATCH_KIND(MATCH_KIND)) u_dec (
    .word_i (in_word),
    .dec_o  (dec)
  );

  pkt_payload_reg #(.W(PAY_W)) u_pay (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .load  (dec.hit),
    .d     (dec.pay),
    .q     (payload_o)
  );

  assign inc_vec = {dec.bad, dec.hit};

  for (genvar g = 0; g < N_CNT; g++) begin : g_cnt
    pkt_wrap_counter #(.W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .inc   (inc_vec[g]),
      .q     (cnt_arr[g])
    );
  end

  assign pkt_cnt_o = cnt_arr[0];
  assign err_cnt_o = cnt_arr[1];

  // An error step never happens without a packet step
  assert_err_needs_pkt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && (err_cnt_o != $past(err_cnt_o)) && !$past(clr) && $past(rst_n))
      |-> (pkt_cnt_o != $past(pkt_cnt_o)));
endmodule

// File: tb/pkt_hdr_filter_tb_top.sv
`timescale 1ns/1ps
module pkt_hdr_filter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        clr;
  logic [11:0] in_word;
  logic [3:0]  payload_o;
  logic [7:0]  pkt_cnt_o;
  logic [7:0]  err_cnt_o;

  int n_chk = 0;
  int n_bad = 0;
  logic [3:0] m_pay;
  logic [7:0] m_pkt, m_err;

  always #2.5 clk = ~clk;

  pkt_hdr_filter dut_i (
    .clk(clk), .rst_n(rst_n), .clr(clr), .in_word(in_word),
    .payload_o(payload_o), .pkt_cnt_o(pkt_cnt_o), .err_cnt_o(err_cnt_o)
  );

  function automatic int ones4(input logic [3:0] v);
    int c = 0;
    for (int i = 0; i < 4; i++) if (v[i]) c++;
    return c;
  endfunction

  // Expected effect of one edge, taken from the requirements
  function automatic void model_step(input logic r, input logic c, input logic [11:0] w);
    if (!r || c) begin m_pay = 0; m_pkt = 0; m_err = 0; end
    else if (w[11:8] == 4'd1) begin
      m_pay = w[7:4];
      m_pkt = m_pkt + 8'd1;
      if (w[0] ? (ones4(w[7:4]) % 2 != 0) : (ones4(w[7:4]) % 2 == 0)) m_err = m_err + 8'd1;
    end
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " payload"}, {4'h0, payload_o}, {4'h0, m_pay});
    chk({req, " pkt"},     pkt_cnt_o, m_pkt);
    chk({req, " err"},     err_cnt_o, m_err);
  endtask

  // Drive at falling edge, apply at rising edge, sample just after
  task automatic step(input logic r, input logic c, input logic [11:0] w, input string req);
    @(negedge clk);
    rst_n = r; clr = c; in_word = w;
    @(posedge clk);
    model_step(r, c, w);
    #1;
    chk_all(req);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [11:0] w;
    logic [3:0]  keep;
    int unsigned seed_v;
    seed_v = $urandom(32'd4242);
    rst_n = 1'b0; clr = 1'b0; in_word = 12'h1F1;
    m_pay = 0; m_pkt = 0; m_err = 0;
    // R6: reset with a matching word present
    step(1'b0, 1'b0, 12'h1F1, "R6 reset");
    step(1'b0, 1'b0, 12'h131, "R6 reset");
    // R11 / R1 / R2: worked example
    step(1'b1, 1'b0, 12'h1F1, "R11 first");
    step(1'b1, 1'b0, 12'h0E0, "R11 second");
    step(1'b1, 1'b0, 12'h171, "R11 third");
    chk("R11 final pkt", pkt_cnt_o, 8'd2);
    chk("R11 final err", err_cnt_o, 8'd1);
    chk("R11 final payload", {4'h0, payload_o}, 8'h07);
    // R4: each mode with good and bad parity
    step(1'b1, 1'b0, 12'h130, "R4 odd wanted, even ones");
    step(1'b1, 1'b0, 12'h180, "R4 odd wanted, odd ones");
    step(1'b1, 1'b0, 12'h161, "R4 even wanted, even ones");
    step(1'b1, 1'b0, 12'h1E1, "R4 even wanted, odd ones");
    // R5: other kinds hold everything
    keep = payload_o;
    step(1'b1, 1'b0, 12'h2A1, "R5 kind 2");
    step(1'b1, 1'b0, 12'hF00, "R5 kind F");
    step(1'b1, 1'b0, 12'h011, "R5 kind 0");
    chk("R5 payload held", {4'h0, payload_o}, {4'h0, keep});
    // R10: spare bits do not matter
    step(1'b1, 1'b0, 12'h15F, "R10 spare set");
    step(1'b1, 1'b0, 12'h150, "R10 spare clear");
    // R7: clear wins over a matching word
    step(1'b1, 1'b1, 12'h1E0, "R7 clear with match");
    chk("R7 pkt zero", pkt_cnt_o, 8'd0);
    // R9: back-to-back matching words
    for (int i = 0; i < 6; i++)
      step(1'b1, 1'b0, {4'h1, 4'(i + 9), 4'(i)}, "R9 back-to-back");
    chk("R9 six counted", pkt_cnt_o, 8'd6);
    // R8: wrap of both counters (all error words)
    step(1'b1, 1'b1, 12'h000, "R8 clear");
    for (int i = 0; i < 256; i++) step(1'b1, 1'b0, 12'h1F0, "R8 wrap");
    chk("R8 pkt wrapped", pkt_cnt_o, 8'd0);
    chk("R8 err wrapped", err_cnt_o, 8'd0);
    step(1'b1, 1'b0, 12'h1F0, "R8 after wrap");
    chk("R8 pkt one", pkt_cnt_o, 8'd1);
    // Random mix, R3/R4/R5/R7
    for (int i = 0; i < 3000; i++) begin
      w = 12'($urandom);
      if ($urandom_range(1, 0) == 1) w[11:8] = 4'h1;
      step(1'b1, ($urandom_range(19, 0) == 0), w, "R3 R4 R5 R7 random");
    end
    // R6 mid-run reset
    step(1'b0, 1'b0, 12'h1F1, "R6 late reset");
    finish_run();
  end
endmodule